// File: doc/BRIEF.md
# Banked Register Access Controller

This block sits behind a serial bus front end. It decides what happens to each single-byte register access. An access arrives with these fields:

- a two-bit bank number
- an eight-bit location within the bank
- a read/write flag and write data
- the chip-select bit taken from the instruction

The address space holds four banks of 256 locations each. Only a few of those locations exist. The block checks whether the device is addressed at all and whether the location exists. It then applies the protection policy: a test-only bank, a trim byte that only test mode may write, two secret regions that can be locked, and a write lock on the non-volatile array. After that it performs the access. One cycle later it answers with read data, a bus-error flag or an ignore flag.

The non-volatile array is modelled as a bank of 16 plain registers. Configuration fields read from its first byte are held in shadow registers. These shadows are refreshed only by a reset: either the block reset, which loads the factory image, or a soft reset requested through the master control register. Programming the array therefore has no effect on behaviour until the next reload. The hash engine is outside this block; its result byte enters on a port and is read back through the authentication location.

Top module: `banked_reg_ctrl`

## Requirements
- R1: Device select follows the loaded two-bit match mode (configuration byte bits 7:6). Mode 00 accepts only chip-select 0, mode 11 accepts only chip-select 1, and modes 01 and 10 accept either. An access that is not selected is answered with the ignore flag and changes no state.
- R2: Any selected access to bank 3 outside test mode is answered with the bus-error flag. Inside test mode, bank 3 has no implemented location, so the access is ignored.
- R3: The implemented locations are bank 0 offsets 0x00–0x0F, bank 1 offsets 0x00–0x01 and bank 2 offsets 0x00–0x05. Every other location is answered with the ignore flag, reads 0x00 and changes no state.
- R4: Each access is answered exactly one cycle later with rsp_valid. The error and ignore flags are never set together, and whenever either is set rsp_rdata is 0x00. A write answers with rsp_rdata 0x00.
- R5: Bank 0 offset 0x01 (trim) accepts writes only in test mode. Outside test mode a write to it is ignored and leaves the stored value unchanged.
- R6: When loaded lock bit 1 is set, bank 0 offsets 0x02–0x09 are blocked. When loaded lock bit 0 is set, offsets 0x0A–0x0D are blocked. The lock bits are configuration bits 1:0. A blocked read returns 0x00 with the error flag. A blocked write is dropped with the error flag. Every error answer sets the sticky status error bit.
- R7: Once a reload sees a non-zero lock field, every write to bank 0 is ignored until the block reset.
- R8: The block reset loads the factory image: 0x1C at bank 0 offset 0x00 and 0x00 elsewhere. Array writes reach the shadow configuration only at the next reload.
- R9: Master control is bank 1 offset 0x00. It stores write data masked to bits 7, 6, 1 and 0. Bits 6 and 1 are loaded from configuration bits 3 and 2 on every reload. Writing 1 to bit 0 starts a reload on the following cycle, and bit 0 then reads back as 0.
- R10: Status is bank 1 offset 0x01 and reads {0, error, 0, 0, match mode[1:0], lock[1:0]}. A read of status clears the error bit, and writes to status are ignored.
- R11: In bank 2, offset 0x00 keeps the low four bits of write data. Offsets 0x01–0x04 hold the four challenge bytes. Offset 0x05 reads the hash_result input, and writes to offset 0x05 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads factory image and shadows |
| test_mode | input | 1 | Test mode qualifier |
| acc_valid | input | 1 | One access presented this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_bank | input | 2 | Bank number |
| acc_addr | input | 8 | Location within the bank |
| acc_wdata | input | 8 | Write data |
| acc_cs | input | 1 | Chip-select bit of the instruction |
| hash_result | input | 8 | Authentication result from the hash engine |
| rsp_valid | output | 1 | Response for the access of the previous cycle |
| rsp_rdata | output | 8 | Read data, 0x00 unless a read succeeded |
| rsp_err | output | 1 | Bus error |
| rsp_ign | output | 1 | Access ignored |

## Verification
The assertions assume that a soft reset's reload cycle never coincides with another access. They also assume that test_mode and acc_cs stay steady while acc_valid is high. The stimulus respects both. It inserts an idle cycle after every soft-reset write, and it changes inputs only on the falling edge before an access. The bench first sweeps every location of banks 0 to 2 with writes to absent locations and reads of all locations, and it sweeps bank 3 in both modes. It then walks the configuration through match modes 00, 01 and 11 and locks secret region one, checking each protection rule before and after each reload.

// File: rtl/brac_pkg.sv
// Shared sizes and types for the banked register access controller.
// Assumes byte-wide data and a two-bit bank field.
package brac_pkg;
    localparam int BANK_W     = 2;
    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 8;
    localparam int OTP_DEPTH  = 16;
    localparam int CHLG_BYTES = 4;
    localparam int SESL_W     = 4;

    typedef enum logic [1:0] {OUT_OK, OUT_IGN, OUT_ERR} outcome_e;

    typedef enum logic [2:0] {
        LOC_NONE, LOC_OTP, LOC_MSCR, LOC_STAT, LOC_SESL, LOC_CHLG, LOC_AUTH
    } loc_e;
endpackage

// File: rtl/brac_decode.sv
// Location decoder: classifies bank/address into a target and flags the
// protection classes (test-only bank, blocked secret, read-only target).
// Assumes the lock field is the loaded shadow copy, not the live array.
module brac_decode
    import brac_pkg::*;
#(
    parameter int AW         = ADDR_W,
    parameter int OTP_N      = OTP_DEPTH,
    parameter int CHLG_N     = CHLG_BYTES,
    parameter int IDX_W      = $clog2(CHLG_N)
) (
    input  logic [BANK_W-1:0] bank,
    input  logic [AW-1:0]     addr,
    input  logic              test_mode,
    input  logic [1:0]        lock,
    output loc_e              loc,
    output logic [IDX_W-1:0]  chlg_idx,
    output logic              test_bank_err,
    output logic              secret_blk,
    output logic              read_only
);
    localparam logic [AW-1:0] TRIM_LOC = AW'(1);
    localparam logic [AW-1:0] SA_LO    = AW'(2);
    localparam logic [AW-1:0] SA_HI    = AW'(9);
    localparam logic [AW-1:0] SB_LO    = AW'(10);
    localparam logic [AW-1:0] SB_HI    = AW'(13);
    localparam logic [AW-1:0] CH_LO    = AW'(1);
    localparam logic [AW-1:0] CH_HI    = AW'(CHLG_N);
    localparam logic [AW-1:0] AUTH_LOC = AW'(CHLG_N + 1);

    // Target selection per bank.
    always_comb begin
        loc = LOC_NONE;
        unique case (bank)
            2'd0: if (addr < AW'(OTP_N)) loc = LOC_OTP;
            2'd1: begin
                if (addr == AW'(0)) loc = LOC_MSCR;
                else if (addr == AW'(1)) loc = LOC_STAT;
            end
            2'd2: begin
                if (addr == AW'(0)) loc = LOC_SESL;
                else if (addr >= CH_LO && addr <= CH_HI) loc = LOC_CHLG;
                else if (addr == AUTH_LOC) loc = LOC_AUTH;
            end
            default: loc = LOC_NONE;
        endcase
    end

    // Challenge byte index and protection classes.
    always_comb begin
        chlg_idx      = IDX_W'(addr - CH_LO);
        test_bank_err = (bank == 2'd3) && !test_mode;
        secret_blk    = (loc == LOC_OTP) &&
                        ((lock[1] && addr >= SA_LO && addr <= SA_HI) ||
                         (lock[0] && addr >= SB_LO && addr <= SB_HI));
        read_only     = (loc == LOC_STAT) || (loc == LOC_AUTH) ||
                        ((loc == LOC_OTP) && (addr == TRIM_LOC) && !test_mode);
    end
endmodule

// File: rtl/brac_otp.sv
// Non-volatile array model with shadow configuration. The block reset loads
// the factory image; a reload copies match mode and lock bits from byte 0
// and arms the sticky write lock if any lock bit is set.
// Assumes the caller never asserts wr_en while the write lock is set.
module brac_otp #(
    parameter int                DEPTH   = brac_pkg::OTP_DEPTH,
    parameter int                DW      = brac_pkg::DATA_W,
    parameter logic [DW-1:0]     FACTORY = 8'h1C,
    parameter int                AW      = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          reload,
    output logic [DW-1:0] rdata,
    output logic [1:0]    dab,
    output logic [1:0]    lock,
    output logic          wlock,
    output logic          def_eint,
    output logic          def_aslp
);
    logic [DW-1:0] mem [DEPTH];

    // Array storage: factory image on reset, byte writes otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= (i == 0) ? FACTORY : '0;
        end else if (wr_en) begin
            mem[addr] <= wdata;
        end
    end

    // Shadow configuration and sticky write lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dab   <= FACTORY[7:6];
            lock  <= FACTORY[1:0];
            wlock <= |FACTORY[1:0];
        end else if (reload) begin
            dab   <= mem[0][7:6];
            lock  <= mem[0][1:0];
            wlock <= wlock | (|mem[0][1:0]);
        end
    end

    assign rdata    = mem[addr];
    assign def_eint = mem[0][3];
    assign def_aslp = mem[0][2];

    a_r7_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        wlock |=> wlock);
    a_r7_locked_cfg_stable: assert property (@(posedge clk) disable iff (!rst_n)
        wlock |=> $stable(mem[0]));
    a_r8_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !reload |=> ($stable(dab) && $stable(lock)));
endmodule

// File: rtl/brac_regs.sv
// Control, status and authentication registers: master control with a
// self-clearing soft-reset bit, sticky error flag cleared on status read,
// secret select and challenge bytes.
// Assumes at most one write enable is active per cycle.
module brac_regs #(
    parameter int            DW     = brac_pkg::DATA_W,
    parameter int            CHLG_N = brac_pkg::CHLG_BYTES,
    parameter int            SEL_W  = brac_pkg::SESL_W,
    parameter logic [DW-1:0] FACTORY = 8'h1C,
    parameter int            IDX_W  = $clog2(CHLG_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_mscr,
    input  logic             wr_sesl,
    input  logic             wr_chlg,
    input  logic [IDX_W-1:0] chlg_idx,
    input  logic [DW-1:0]    wdata,
    input  logic             def_eint,
    input  logic             def_aslp,
    input  logic             ber_set,
    input  logic             stat_rd,
    output logic [DW-1:0]    mscr,
    output logic [SEL_W-1:0] sesl,
    output logic [DW-1:0]    chlg_rd,
    output logic             sber,
    output logic             reload
);
    localparam logic [DW-1:0] MSCR_MASK = 8'hC3;
    logic [DW-1:0] chlg [CHLG_N];

    // Master control: masked writes, defaults reloaded, soft-reset bit self-clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mscr <= {1'b0, FACTORY[3], 4'b0, FACTORY[2], 1'b0};
        end else begin
            if (wr_mscr) mscr <= wdata & MSCR_MASK;
            if (reload) begin
                mscr[6] <= def_eint;
                mscr[1] <= def_aslp;
                mscr[0] <= 1'b0;
            end
        end
    end

    assign reload = mscr[0];

    // Sticky error flag, cleared by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n)       sber <= 1'b0;
        else if (ber_set) sber <= 1'b1;
        else if (stat_rd) sber <= 1'b0;
    end

    // Secret select register.
    always_ff @(posedge clk) begin
        if (!rst_n)       sesl <= '0;
        else if (wr_sesl) sesl <= wdata[SEL_W-1:0];
    end

    // Challenge bytes, one register per byte.
    for (genvar g = 0; g < CHLG_N; g++) begin : g_chlg
        always_ff @(posedge clk) begin
            if (!rst_n)                                  chlg[g] <= '0;
            else if (wr_chlg && chlg_idx == IDX_W'(g))   chlg[g] <= wdata;
        end
    end

    assign chlg_rd = chlg[chlg_idx];

    a_r9_srst_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        mscr[0] |=> !mscr[0]);
    a_r10_err_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !ber_set) |=> !sber);
    a_r6_err_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ber_set |=> sber);
endmodule

// File: rtl/banked_reg_ctrl.sv
// Banked register access controller top. Applies device select, bank and
// location checks, protection policy, performs the access and returns a
// registered response one cycle later.
// Assumes one access per acc_valid cycle and no access in a reload cycle.
module banked_reg_ctrl
    import brac_pkg::*;
#(
    parameter logic [DATA_W-1:0] FACTORY_CFG = 8'h1C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              test_mode,
    input  logic              acc_valid,
    input  logic              acc_wr,
    input  logic [BANK_W-1:0] acc_bank,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic              acc_cs,
    input  logic [DATA_W-1:0] hash_result,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic              rsp_ign
);
    localparam int OTP_AW = $clog2(OTP_DEPTH);
    localparam int IDX_W  = $clog2(CHLG_BYTES);

    loc_e              loc;
    logic [IDX_W-1:0]  chlg_idx;
    logic              test_bank_err, secret_blk, read_only;
    logic [DATA_W-1:0] otp_rdata, mscr, chlg_rd, rd_mux;
    logic [SESL_W-1:0] sesl;
    logic [1:0]        dab, lock;
    logic              wlock, def_eint, def_aslp, sber, reload;
    logic              dev_sel, go;
    outcome_e          outcome;

    brac_decode u_decode (
        .bank(acc_bank), .addr(acc_addr), .test_mode(test_mode), .lock(lock),
        .loc(loc), .chlg_idx(chlg_idx), .test_bank_err(test_bank_err),
        .secret_blk(secret_blk), .read_only(read_only)
    );

    // Device select against the loaded match mode.
    always_comb begin
        unique case (dab)
            2'b00:   dev_sel = !acc_cs;
            2'b11:   dev_sel = acc_cs;
            default: dev_sel = 1'b1;
        endcase
    end

    // Outcome priority: select, test bank, existence, secret lock, write protection.
    always_comb begin
        outcome = OUT_OK;
        if (!dev_sel)                                        outcome = OUT_IGN;
        else if (test_bank_err)                              outcome = OUT_ERR;
        else if (loc == LOC_NONE)                            outcome = OUT_IGN;
        else if (secret_blk)                                 outcome = OUT_ERR;
        else if (acc_wr && (read_only || (loc == LOC_OTP && wlock)))
                                                             outcome = OUT_IGN;
    end

    assign go = acc_valid && (outcome == OUT_OK);

    brac_otp #(.FACTORY(FACTORY_CFG)) u_otp (
        .clk(clk), .rst_n(rst_n),
        .wr_en(go && acc_wr && loc == LOC_OTP),
        .addr(acc_addr[OTP_AW-1:0]), .wdata(acc_wdata), .reload(reload),
        .rdata(otp_rdata), .dab(dab), .lock(lock), .wlock(wlock),
        .def_eint(def_eint), .def_aslp(def_aslp)
    );

    brac_regs #(.FACTORY(FACTORY_CFG)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_mscr(go && acc_wr && loc == LOC_MSCR),
        .wr_sesl(go && acc_wr && loc == LOC_SESL),
        .wr_chlg(go && acc_wr && loc == LOC_CHLG),
        .chlg_idx(chlg_idx), .wdata(acc_wdata),
        .def_eint(def_eint), .def_aslp(def_aslp),
        .ber_set(acc_valid && outcome == OUT_ERR),
        .stat_rd(go && !acc_wr && loc == LOC_STAT),
        .mscr(mscr), .sesl(sesl), .chlg_rd(chlg_rd), .sber(sber), .reload(reload)
    );

    // Read data selection by target.
    always_comb begin
        unique case (loc)
            LOC_OTP:  rd_mux = otp_rdata;
            LOC_MSCR: rd_mux = mscr;
            LOC_STAT: rd_mux = {1'b0, sber, 2'b00, dab, lock};
            LOC_SESL: rd_mux = {{(DATA_W-SESL_W){1'b0}}, sesl};
            LOC_CHLG: rd_mux = chlg_rd;
            LOC_AUTH: rd_mux = hash_result;
            default:  rd_mux = '0;
        endcase
    end

    // Registered response, one cycle after the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_ign   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= acc_valid;
            rsp_err   <= acc_valid && outcome == OUT_ERR;
            rsp_ign   <= acc_valid && outcome == OUT_IGN;
            rsp_rdata <= (go && !acc_wr) ? rd_mux : '0;
        end
    end

    a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> rsp_valid);
    a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !rsp_valid);
    a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones({rsp_err, rsp_ign}) <= 1));
    a_r4_quiet_data: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_err || rsp_ign) |-> (rsp_rdata == '0));
    a_r1_unselected_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !dev_sel) |=> rsp_ign);
    a_r2_test_bank_error: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && dev_sel && acc_bank == 2'd3 && !test_mode) |=> rsp_err);
endmodule

// File: tb/banked_reg_ctrl_tb_top.sv
// Self-checking bench: exhaustive location sweeps, then configuration walk.
module banked_reg_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       test_mode = 1'b0;
    logic       acc_valid = 1'b0;
    logic       acc_wr = 1'b0;
    logic [1:0] acc_bank = '0;
    logic [7:0] acc_addr = '0;
    logic [7:0] acc_wdata = '0;
    logic       acc_cs = 1'b0;
    logic [7:0] hash_result = 8'hA5;
    logic       rsp_valid, rsp_err, rsp_ign;
    logic [7:0] rsp_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    banked_reg_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .test_mode(test_mode),
        .acc_valid(acc_valid), .acc_wr(acc_wr), .acc_bank(acc_bank),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_cs(acc_cs),
        .hash_result(hash_result), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_err(rsp_err), .rsp_ign(rsp_ign)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // One access; response sampled 1 ns after the capturing edge.
    task automatic acc(input bit wr, input int b, input int a, input logic [7:0] d,
                       input bit cs);
        @(negedge clk);
        acc_valid = 1'b1; acc_wr = wr; acc_bank = 2'(b); acc_addr = 8'(a);
        acc_wdata = d; acc_cs = cs;
        @(posedge clk);
        #1;
        acc_valid = 1'b0;
    endtask

    // Access then check flags {valid,err,ign} and data.
    task automatic expect_rsp(input string tag, input bit wr, input int b, input int a,
                              input logic [7:0] d, input bit cs, input logic [1:0] fl,
                              input logic [7:0] exp_d);
        acc(wr, b, a, d, cs);
        chk({tag, " flags"}, {5'b0, rsp_valid, rsp_err, rsp_ign}, {5'b0, 1'b1, fl});
        chk({tag, " data"}, rsp_rdata, exp_d);
    endtask

    function automatic bit impl(input int b, input int a);
        return (b == 0 && a < 16) || (b == 1 && a < 2) || (b == 2 && a < 6);
    endfunction

    function automatic logic [7:0] reset_val(input int b, input int a);
        if (b == 0 && a == 0) return 8'h1C;
        if (b == 1 && a == 0) return 8'h42;
        if (b == 2 && a == 5) return 8'hA5;
        return 8'h00;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R4 reset valid", {7'b0, rsp_valid}, 8'h00);
        @(negedge clk); rst_n = 1'b1;

        // R3: writes to every absent location are ignored.
        for (int b = 0; b < 3; b++)
            for (int a = 0; a < 256; a++)
                if (!impl(b, a)) expect_rsp("R3 absent write", 1, b, a, 8'hFF, 0, 2'b01, 8'h00);
        // R3/R8: full read sweep shows factory image and untouched state.
        for (int b = 0; b < 3; b++)
            for (int a = 0; a < 256; a++)
                expect_rsp("R3 R8 sweep read", 0, b, a, 8'h00, 0,
                           impl(b, a) ? 2'b00 : 2'b01, impl(b, a) ? reset_val(b, a) : 8'h00);
        // R2: test bank.
        for (int a = 0; a < 256; a++) expect_rsp("R2 bank3 normal", 0, 3, a, 8'h00, 0, 2'b10, 8'h00);
        test_mode = 1'b1;
        for (int a = 0; a < 256; a += 17) expect_rsp("R2 bank3 test", 1, 3, a, 8'h11, 0, 2'b01, 8'h00);
        test_mode = 1'b0;
        expect_rsp("R10 err after bank3", 0, 1, 1, 8'h00, 0, 2'b00, 8'h40);
        expect_rsp("R10 err cleared", 0, 1, 1, 8'h00, 0, 2'b00, 8'h00);
        expect_rsp("R10 stat write", 1, 1, 1, 8'hFF, 0, 2'b01, 8'h00);

        // R11: bank 2.
        expect_rsp("R11 sesl write", 1, 2, 0, 8'hFF, 0, 2'b00, 8'h00);
        expect_rsp("R11 sesl read", 0, 2, 0, 8'h00, 0, 2'b00, 8'h0F);
        for (int i = 0; i < 4; i++) expect_rsp("R11 chlg write", 1, 2, 1 + i, 8'(8'h10 + i), 0, 2'b00, 8'h00);
        for (int i = 0; i < 4; i++) expect_rsp("R11 chlg read", 0, 2, 1 + i, 8'h00, 0, 2'b00, 8'(8'h10 + i));
        expect_rsp("R11 auth write", 1, 2, 5, 8'h00, 0, 2'b01, 8'h00);
        hash_result = 8'h3C;
        expect_rsp("R11 auth read", 0, 2, 5, 8'h00, 0, 2'b00, 8'h3C);

        // R1: mode 00 rejects chip-select 1 without state change.
        expect_rsp("R1 mode00 cs1 write", 1, 2, 2, 8'hEE, 1, 2'b01, 8'h00);
        expect_rsp("R1 mode00 no change", 0, 2, 2, 8'h00, 0, 2'b00, 8'h11);

        // R9: master control mask.
        expect_rsp("R9 mscr write", 1, 1, 0, 8'hFE, 0, 2'b00, 8'h00);
        expect_rsp("R9 mscr mask", 0, 1, 0, 8'h00, 0, 2'b00, 8'hC2);

        // R5: trim protection.
        expect_rsp("R5 trim normal write", 1, 0, 1, 8'h5A, 0, 2'b01, 8'h00);
        expect_rsp("R5 trim unchanged", 0, 0, 1, 8'h00, 0, 2'b00, 8'h00);
        test_mode = 1'b1;
        expect_rsp("R5 trim test write", 1, 0, 1, 8'h5A, 0, 2'b00, 8'h00);
        test_mode = 1'b0;
        expect_rsp("R5 trim stored", 0, 0, 1, 8'h00, 0, 2'b00, 8'h5A);

        // Secrets before lock.
        expect_rsp("R6 secret write open", 1, 0, 5, 8'h77, 0, 2'b00, 8'h00);
        expect_rsp("R6 secret write open b", 1, 0, 11, 8'h66, 0, 2'b00, 8'h00);

        // R8: config write without reload has no effect; mode 01 after reload.
        expect_rsp("R8 cfg write 5C", 1, 0, 0, 8'h5C, 0, 2'b00, 8'h00);
        expect_rsp("R8 no effect yet", 0, 1, 1, 8'h00, 1, 2'b01, 8'h00);
        expect_rsp("R9 soft reset", 1, 1, 0, 8'h01, 0, 2'b00, 8'h00);
        @(negedge clk);
        expect_rsp("R10 stat mode01", 0, 1, 1, 8'h00, 1, 2'b00, 8'h04);
        expect_rsp("R1 mode01 cs0", 0, 1, 1, 8'h00, 0, 2'b00, 8'h04);
        expect_rsp("R9 mscr after reload", 0, 1, 0, 8'h00, 0, 2'b00, 8'h42);

        // Mode 11 with secret region one locked.
        expect_rsp("R8 cfg write C6", 1, 0, 0, 8'hC6, 0, 2'b00, 8'h00);
        expect_rsp("R9 soft reset 2", 1, 1, 0, 8'h01, 1, 2'b00, 8'h00);
        @(negedge clk);
        expect_rsp("R1 mode11 cs0", 0, 1, 1, 8'h00, 0, 2'b01, 8'h00);
        expect_rsp("R10 stat mode11", 0, 1, 1, 8'h00, 1, 2'b00, 8'h0E);
        expect_rsp("R9 eint aslp reload", 0, 1, 0, 8'h00, 1, 2'b00, 8'h02);
        expect_rsp("R6 locked read", 0, 0, 5, 8'h00, 1, 2'b10, 8'h00);
        expect_rsp("R6 locked write", 1, 0, 9, 8'h12, 1, 2'b10, 8'h00);
        expect_rsp("R6 err flag", 0, 1, 1, 8'h00, 1, 2'b00, 8'h4E);
        expect_rsp("R10 err cleared 2", 0, 1, 1, 8'h00, 1, 2'b00, 8'h0E);
        expect_rsp("R6 other region open", 0, 0, 11, 8'h00, 1, 2'b00, 8'h66);

        // R7: array write lock.
        expect_rsp("R7 locked write", 1, 0, 14, 8'h33, 1, 2'b01, 8'h00);
        expect_rsp("R7 locked unchanged", 0, 0, 14, 8'h00, 1, 2'b00, 8'h00);
        expect_rsp("R7 cfg write locked", 1, 0, 0, 8'h00, 1, 2'b01, 8'h00);
        expect_rsp("R7 cfg unchanged", 0, 0, 0, 8'h00, 1, 2'b00, 8'hC6);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule